// File: doc/BRIEF.md
# Configurable Microcontroller Bus Front End

This block sits between an 8-bit microcontroller bus and the internal logic of a peripheral. It produces a clean, clock-synchronous view of each bus cycle: a 16-bit address, a read-active level, a one-cycle write event with its data byte, and a read data path back towards the bus. Configuration inputs select four things. The first is the bus shape: a multiplexed address/data bus, where an address strobe captures the address, or a non-multiplexed bus with sixteen address lines and a separate data port. The second is the active level of the address strobe. The third is the active level of the reset input. The fourth is the control convention: separate read and write strobes, or a read/write direction line qualified by an enable pulse that is active high or a data strobe that is active low. A code-fetch strobe, active low, is accepted as an extra read source in every convention.

Every bus pin passes through a synchronizer chain of `SYNC_STAGES` registers, and the results are then registered once more. With the defaults, every result therefore appears a fixed three clocks after the pins change. Written bytes leave on a valid-only stream (`wr_valid`, `wr_data`) that has no ready. A microcontroller bus cannot be stalled, so the consumer must accept every beat in the cycle it is offered. `bus_doe` tells the pad logic when to drive `bus_dout` onto the data lines.

Top module: `mcu_bus_frontend`

## Requirements
- R1: The reset input is active high when `cfg_rst_hi` is 1 and active low when it is 0. The reset is synchronous. One clock after reset is asserted, `addr` is 0, `rd_active` is 0 and `wr_valid` is 0.
- R2: In multiplexed mode (`cfg_muxed`=1), the address from {`bus_ahi`,`bus_ad`} is captured while the address strobe is active. After the strobe goes inactive, that address is held on `addr` even when the address/data lines change.
- R3: The address strobe is active when `bus_as` equals `cfg_as_hi`. While the strobe is inactive, changes on the address lines do not reach `addr` in multiplexed mode.
- R4: In non-multiplexed mode (`cfg_muxed`=0), `addr` follows {`bus_ahi`,`bus_ad`} whatever the state of the strobe.
- R5: With `cfg_rw_style`=0, `bus_rd_e` low is a read and `bus_wr_rw` low is a write.
- R6: With `cfg_rw_style`=1 and `cfg_ds_sel`=0, `bus_rd_e` is an active-high enable. Enable high with `bus_wr_rw` high is a read. Enable high with `bus_wr_rw` low is a write. With the enable low, neither is signalled.
- R7: With `cfg_rw_style`=1 and `cfg_ds_sel`=1, `bus_rd_e` is an active-low data strobe, qualified by `bus_wr_rw` in the same way as in R6.
- R8: `bus_psen_n` low drives `rd_active` high in every control style.
- R9: `wr_valid` is high for exactly one clock at the leading edge of each write. In that clock `wr_data` holds the byte on `bus_ad` in multiplexed mode, or the byte on `bus_dp` in non-multiplexed mode. `wr_data` keeps that byte until the next write.
- R10: `addr`, `rd_active` and `wr_valid` respond exactly SYNC_STAGES+1 clocks after the pins change. `bus_doe` equals `rd_active`, and `bus_dout` carries `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_raw | input | 1 | Reset input; its active level is set by cfg_rst_hi |
| cfg_rst_hi | input | 1 | 1: reset active high, 0: reset active low |
| cfg_muxed | input | 1 | 1: multiplexed address/data, 0: separate address and data |
| cfg_as_hi | input | 1 | Active level of the address strobe |
| cfg_rw_style | input | 1 | 0: separate read/write strobes, 1: direction line plus pulse |
| cfg_ds_sel | input | 1 | With style 1: 0 enable active high, 1 data strobe active low |
| bus_as | input | 1 | Address strobe |
| bus_rd_e | input | 1 | Read strobe (active low), enable, or data strobe |
| bus_wr_rw | input | 1 | Write strobe (active low), or direction (1 read, 0 write) |
| bus_psen_n | input | 1 | Code-fetch read strobe, active low |
| bus_ad | input | 8 | Low address byte, or multiplexed address/data |
| bus_ahi | input | 8 | High address byte |
| bus_dp | input | 8 | Data port in non-multiplexed mode |
| rd_data | input | 8 | Read byte from the internal logic |
| addr | output | 16 | Registered cycle address |
| rd_active | output | 1 | Read cycle in progress |
| wr_valid | output | 1 | One-clock write beat; there is no ready |
| wr_data | output | 8 | Write byte, valid while wr_valid is high |
| bus_dout | output | 8 | Byte to drive onto the bus data lines |
| bus_doe | output | 1 | Drive enable for bus_dout |

## Verification
Each result is due three clocks after the pins move: two synchronizer stages and one output register. Reset takes effect one clock after it is asserted. The bench changes pins on a falling edge and then waits exactly three falling edges before it samples. Since `wr_valid` lasts one clock, a sample one falling edge later confirms that the pulse has ended. The latency check samples at two falling edges to confirm the old value, and then at three to confirm the new one. Configuration changes are followed by settling time that the bench does not check, because the configuration inputs are not synchronized and a change can cause short transients.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  typedef enum logic [1:0] {
    STY_SPLIT = 2'd0,
    STY_ENABLE = 2'd1,
    STY_DSTROBE = 2'd2
  } ctl_style_t;

  typedef struct packed {
    logic as_pin;
    logic rd_e_pin;
    logic wr_rw_pin;
    logic psen_n_pin;
  } ctl_pins_t;
endpackage

// File: rtl/mfe_sync.sv
module mfe_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mfe_decode.sv
module mfe_decode
  import mfe_pkg::*;
(
  input  ctl_style_t style,
  input  ctl_pins_t  pins,
  output logic       rd_req,
  output logic       wr_req
);
  logic pulse_on;

  always_comb begin
    rd_req   = 1'b0;
    wr_req   = 1'b0;
    pulse_on = 1'b0;
    unique case (style)
      STY_SPLIT: begin
        rd_req = ~pins.rd_e_pin;
        wr_req = ~pins.wr_rw_pin;
      end
      STY_ENABLE, STY_DSTROBE: begin
        pulse_on = (style == STY_ENABLE) ? pins.rd_e_pin : ~pins.rd_e_pin;
        rd_req   = pulse_on & pins.wr_rw_pin;
        wr_req   = pulse_on & ~pins.wr_rw_pin;
      end
      default: begin
        rd_req = 1'b0;
        wr_req = 1'b0;
      end
    endcase
    rd_req = rd_req | ~pins.psen_n_pin;
  end
endmodule

// File: rtl/mfe_addr.sv
module mfe_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              muxed,
  input  logic              as_act,
  input  logic [ADDR_W-1:0] pin_addr,
  output logic [ADDR_W-1:0] addr_next
);
  logic [ADDR_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)
      held_q <= '0;
    else if (muxed && as_act)
      held_q <= pin_addr;
  end

  always_comb begin
    if (!muxed || as_act)
      addr_next = pin_addr;
    else
      addr_next = held_q;
  end

  // R2 / R3: with the strobe inactive in multiplexed mode, the held address stays put
  a_r2_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
    (muxed && !as_act) |=> $stable(held_q));
endmodule

// File: rtl/mcu_bus_frontend.sv
module mcu_bus_frontend
  import mfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_raw,
  input  logic                   cfg_rst_hi,
  input  logic                   cfg_muxed,
  input  logic                   cfg_as_hi,
  input  logic                   cfg_rw_style,
  input  logic                   cfg_ds_sel,
  input  logic                   bus_as,
  input  logic                   bus_rd_e,
  input  logic                   bus_wr_rw,
  input  logic                   bus_psen_n,
  input  logic [DATA_W-1:0]      bus_ad,
  input  logic [HI_W-1:0]        bus_ahi,
  input  logic [DATA_W-1:0]      bus_dp,
  input  logic [DATA_W-1:0]      rd_data,
  output logic [HI_W+DATA_W-1:0] addr,
  output logic                   rd_active,
  output logic                   wr_valid,
  output logic [DATA_W-1:0]      wr_data,
  output logic [DATA_W-1:0]      bus_dout,
  output logic                   bus_doe
);
  localparam int ADDR_W = HI_W + DATA_W;
  localparam int CTL_W  = $bits(ctl_pins_t);
  localparam int SYN_W  = CTL_W + 2 * DATA_W + HI_W;

  logic rst;
  assign rst = cfg_rst_hi ? rst_raw : ~rst_raw;

  ctl_pins_t raw_ctl, s_ctl;
  logic [DATA_W-1:0] s_ad, s_dp;
  logic [HI_W-1:0]   s_ahi;
  logic [SYN_W-1:0]  syn_in, syn_out;

  assign raw_ctl = '{as_pin: bus_as, rd_e_pin: bus_rd_e,
                     wr_rw_pin: bus_wr_rw, psen_n_pin: bus_psen_n};
  assign syn_in  = {raw_ctl, bus_ahi, bus_ad, bus_dp};

  mfe_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (syn_in),
    .q   (syn_out)
  );

  assign {s_ctl, s_ahi, s_ad, s_dp} = syn_out;

  ctl_style_t style;
  always_comb begin
    if (!cfg_rw_style)   style = STY_SPLIT;
    else if (cfg_ds_sel) style = STY_DSTROBE;
    else                 style = STY_ENABLE;
  end

  logic rd_req, wr_req;
  mfe_decode u_dec (
    .style  (style),
    .pins   (s_ctl),
    .rd_req (rd_req),
    .wr_req (wr_req)
  );

  logic as_act;
  assign as_act = (s_ctl.as_pin == cfg_as_hi);

  logic [ADDR_W-1:0] addr_next;
  mfe_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .muxed     (cfg_muxed),
    .as_act    (as_act),
    .pin_addr  ({s_ahi, s_ad}),
    .addr_next (addr_next)
  );

  logic wr_level;
  logic wr_lead;
  assign wr_lead = wr_req & ~wr_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr      <= '0;
      rd_active <= 1'b0;
      wr_level  <= 1'b0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
    end else begin
      addr      <= addr_next;
      rd_active <= rd_req;
      wr_level  <= wr_req;
      wr_valid  <= wr_lead;
      if (wr_lead)
        wr_data <= cfg_muxed ? s_ad : s_dp;
    end
  end

  assign bus_doe  = rd_active;
  assign bus_dout = rd_data;

  // R9: a write beat never lasts two clocks
  a_r9_single_beat: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  // R9: a beat marks a write level that was low the clock before
  a_r9_leading_edge: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_level && !$past(wr_level)));

  // R1: one clock after reset the outputs are idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (addr == '0 && !rd_active && !wr_valid));

  // R9: write data only changes together with a beat
  a_r9_data_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> $stable(wr_data) || $past(rst));
endmodule

// File: tb/sim_mcu_bus_frontend.sv
module sim_mcu_bus_frontend;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_raw, cfg_rst_hi, cfg_muxed, cfg_as_hi, cfg_rw_style, cfg_ds_sel;
  logic bus_as, bus_rd_e, bus_wr_rw, bus_psen_n;
  logic [7:0] bus_ad, bus_ahi, bus_dp, rd_data;
  logic [15:0] addr;
  logic rd_active, wr_valid, bus_doe;
  logic [7:0] wr_data, bus_dout;

  int n_chk = 0;
  int n_bad = 0;

  mcu_bus_frontend u0 (
    .clk(clk), .rst_raw(rst_raw), .cfg_rst_hi(cfg_rst_hi), .cfg_muxed(cfg_muxed),
    .cfg_as_hi(cfg_as_hi), .cfg_rw_style(cfg_rw_style), .cfg_ds_sel(cfg_ds_sel),
    .bus_as(bus_as), .bus_rd_e(bus_rd_e), .bus_wr_rw(bus_wr_rw),
    .bus_psen_n(bus_psen_n), .bus_ad(bus_ad), .bus_ahi(bus_ahi), .bus_dp(bus_dp),
    .rd_data(rd_data), .addr(addr), .rd_active(rd_active), .wr_valid(wr_valid),
    .wr_data(wr_data), .bus_dout(bus_dout), .bus_doe(bus_doe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_low;
    cfg_rst_hi = 1'b0; rst_raw = 1'b0;
    step(4);
    chk("R1 addr in low reset", addr, 16'h0000);
    chk("R1 rd in low reset", {15'd0, rd_active}, 16'd0);
    chk("R1 wr in low reset", {15'd0, wr_valid}, 16'd0);
    rst_raw = 1'b1;
    step(4);
  endtask

  task automatic t_muxed_hold;
    cfg_muxed = 1'b1; cfg_as_hi = 1'b1;
    bus_ahi = 8'h12; bus_ad = 8'h34; bus_as = 1'b1;
    step(3);
    chk("R2 capture during strobe", addr, 16'h1234);
    bus_as = 1'b0;
    step(3);
    bus_ahi = 8'h77; bus_ad = 8'h99;
    step(3);
    chk("R2 held after strobe", addr, 16'h1234);
  endtask

  task automatic t_strobe_low;
    cfg_as_hi = 1'b0; bus_as = 1'b1;
    step(4);
    bus_ahi = 8'hAB; bus_ad = 8'hCD;
    step(3);
    chk("R3 inactive high level ignored", addr, 16'h7799);
    bus_as = 1'b0;
    step(3);
    chk("R3 low strobe captures", addr, 16'hABCD);
    bus_as = 1'b1;
    step(1);
    bus_ad = 8'h01;
    step(3);
    chk("R3 held after low strobe", addr, 16'hABCD);
  endtask

  task automatic t_reset_high;
    cfg_rst_hi = 1'b1; rst_raw = 1'b1;
    step(1);
    chk("R1 addr in high reset", addr, 16'h0000);
    rst_raw = 1'b0;
    step(4);
  endtask

  task automatic t_nonmux;
    cfg_muxed = 1'b0; bus_as = 1'b1;
    bus_ahi = 8'h22; bus_ad = 8'h11;
    step(3);
    chk("R4 direct address", addr, 16'h2211);
    bus_ad = 8'h33;
    step(2);
    chk("R10 not yet at two clocks", addr, 16'h2211);
    step(1);
    chk("R10 due at three clocks", addr, 16'h2233);
    chk("R4 follows without strobe", addr, 16'h2233);
  endtask

  task automatic t_split;
    cfg_rw_style = 1'b0; bus_rd_e = 1'b1; bus_wr_rw = 1'b1;
    step(4);
    rd_data = 8'h5A; bus_rd_e = 1'b0;
    step(3);
    chk("R5 read strobe", {15'd0, rd_active}, 16'd1);
    chk("R10 doe follows read", {15'd0, bus_doe}, 16'd1);
    chk("R10 dout carries rd_data", {8'd0, bus_dout}, 16'h005A);
    chk("R5 no write on read", {15'd0, wr_valid}, 16'd0);
    bus_rd_e = 1'b1;
    step(3);
    chk("R5 read ends", {15'd0, rd_active}, 16'd0);
    bus_dp = 8'hC3; bus_wr_rw = 1'b0;
    step(3);
    chk("R5 write beat", {15'd0, wr_valid}, 16'd1);
    chk("R9 data from port", {8'd0, wr_data}, 16'h00C3);
    step(1);
    chk("R9 beat lasts one clock", {15'd0, wr_valid}, 16'd0);
    bus_dp = 8'h00;
    step(3);
    chk("R9 data kept", {8'd0, wr_data}, 16'h00C3);
    bus_wr_rw = 1'b1;
    step(3);
    cfg_muxed = 1'b1; bus_ad = 8'h3C; bus_wr_rw = 1'b0;
    step(3);
    chk("R9 data from AD in muxed", {8'd0, wr_data}, 16'h003C);
    bus_wr_rw = 1'b1;
    step(3);
    bus_psen_n = 1'b0;
    step(3);
    chk("R8 fetch strobe reads", {15'd0, rd_active}, 16'd1);
    bus_psen_n = 1'b1;
    step(3);
  endtask

  task automatic t_enable;
    bus_rd_e = 1'b0; bus_wr_rw = 1'b1;
    cfg_rw_style = 1'b1; cfg_ds_sel = 1'b0;
    step(4);
    chk("R6 idle with enable low", {15'd0, rd_active}, 16'd0);
    bus_rd_e = 1'b1;
    step(3);
    chk("R6 read with enable", {15'd0, rd_active}, 16'd1);
    chk("R6 no write on read", {15'd0, wr_valid}, 16'd0);
    bus_rd_e = 1'b0;
    step(3);
    bus_wr_rw = 1'b0;
    step(3);
    chk("R6 direction alone no write", {15'd0, wr_valid}, 16'd0);
    bus_ad = 8'h6E; bus_rd_e = 1'b1;
    step(3);
    chk("R6 write with enable", {15'd0, wr_valid}, 16'd1);
    chk("R6 write data", {8'd0, wr_data}, 16'h006E);
    bus_rd_e = 1'b0;
    step(3);
    bus_psen_n = 1'b0;
    step(3);
    chk("R8 fetch in enable style", {15'd0, rd_active}, 16'd1);
    bus_psen_n = 1'b1;
    step(3);
  endtask

  task automatic t_dstrobe;
    bus_wr_rw = 1'b1;
    step(3);
    bus_rd_e = 1'b1; cfg_ds_sel = 1'b1;
    step(5);
    chk("R7 idle with strobe high", {15'd0, rd_active}, 16'd0);
    bus_rd_e = 1'b0;
    step(3);
    chk("R7 read with low strobe", {15'd0, rd_active}, 16'd1);
    bus_rd_e = 1'b1;
    step(3);
    bus_wr_rw = 1'b0;
    step(3);
    chk("R7 no write while strobe high", {15'd0, wr_valid}, 16'd0);
    bus_ad = 8'hE1; bus_rd_e = 1'b0;
    step(3);
    chk("R7 write with low strobe", {15'd0, wr_valid}, 16'd1);
    chk("R7 write data", {8'd0, wr_data}, 16'h00E1);
    bus_rd_e = 1'b1;
    step(3);
  endtask

  initial begin
    cfg_rst_hi = 1'b0; rst_raw = 1'b0; cfg_muxed = 1'b1; cfg_as_hi = 1'b1;
    cfg_rw_style = 1'b0; cfg_ds_sel = 1'b0;
    bus_as = 1'b0; bus_rd_e = 1'b1; bus_wr_rw = 1'b1; bus_psen_n = 1'b1;
    bus_ad = 8'h00; bus_ahi = 8'h00; bus_dp = 8'h00; rd_data = 8'h00;
    t_reset_low();
    t_muxed_hold();
    t_strobe_low();
    t_reset_high();
    t_nonmux();
    t_split();
    t_enable();
    t_dstrobe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule